// File: doc/BRIEF.md
# Segmented Data Address Unit

This unit sits between a small 8-bit core and its data RAM. The core issues an 8-bit logical data address. The unit turns it into a 16-bit physical address. A logical address with its top bit set lands in a flat upper bank at 0x0080..0x00FF. A logical address with its top bit clear is placed in a 128-byte segment that the segment register selects.

Four bytes at the top of the flat bank are not RAM. They are the unit's own pointer registers: two RAM pointers, a stack pointer and the segment register. The core reads and writes them with ordinary data accesses. Because they sit in the flat bank, the segment setting never hides them.

An access either takes its logical address from the instruction byte or from one of the two RAM pointers. In the pointer case it can step that pointer up or down by one once the access completes. Only a parameterized number of segments have storage behind them. An access to any other segment is flagged, its write is dropped and its read returns zero.

Top module: `seg_addr_unit`

## Requirements
- R1: A logical address with bit 7 = 1 yields physical address {8'h00, addr}, whatever the segment register holds, and never raises the out-of-range flag.
- R2: A logical address with bit 7 = 0 yields physical address {S, 1'b0, addr[6:0]}, where S is the segment register.
- R3: Logical 0xFC..0xFF are the pointer registers: 0xFC pointer X, 0xFD stack pointer, 0xFE pointer B, 0xFF segment register S. A write there takes effect at the clock edge, and a read returns the current register value in the same cycle.
- R4: With mode_i = 1 the logical address comes from a pointer: ptr_sel_i = 0 picks B, ptr_sel_i = 1 picks X. With mode_i = 0 it comes from dir_addr_i.
- R5: On an indirect access, step_i = 2'b01 adds one to the chosen pointer and step_i = 2'b10 subtracts one, both modulo 256, at the end of the access. step_i = 2'b00 or 2'b11 leaves the pointer unchanged. The step applies even when the access is out of range.
- R6: When bit 7 = 0 and S is not below SEG_COUNT (default 2, giving a highest valid address of 0x017F), oor_o is 1, the write is ignored and rd_data_o is 0x00.
- R7: When a write targets the same pointer that the access steps, the written value is the one kept.
- R8: After reset B, X and S read 0x00 and the stack pointer reads 0x6F. RAM bytes hold no defined value until they are written.
- R9: rd_data_o returns, in the cycle of the access, the byte last written to that physical address. Each implemented segment and the flat bank have separate storage.
- R10: With req_i = 0 nothing is written, no pointer steps, rd_data_o is 0x00 and oor_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request for this cycle |
| mode_i | input | 1 | 0 = address from dir_addr_i, 1 = address from a pointer |
| ptr_sel_i | input | 1 | Pointer for indirect access: 0 = B, 1 = X |
| step_i | input | 2 | Post-modify: 01 increment, 10 decrement, else none |
| dir_addr_i | input | 8 | Logical address from the instruction byte |
| wr_en_i | input | 1 | Write this access |
| wr_data_i | input | 8 | Write data |
| phys_addr_o | output | 16 | Physical address of the access |
| rd_data_o | output | 8 | Read data for the access |
| oor_o | output | 1 | Access falls in an unimplemented segment |

## Verification
The bench goes after the boundary between the flat bank and the segmented half. A design that extends addresses with the top bit set would move 0x90 into segment 1, and one that ignores S would alias segment 1 onto segment 0. The pointer steps are driven through 0xFF to 0x00 and 0x00 to 0xFF, which exposes a missing wrap. A pointer that both steps and is written in the same cycle catches a design that lets the step win. Out-of-range writes are followed by reads of the implemented segments, so a write that leaks into storage shows up. Idle cycles carrying write and step controls show whether the design acts without a request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSV  = 2'b11
  } step_e;

  // slot order follows the mapped offsets 0xFC..0xFF
  typedef enum logic [1:0] {
    PW_X  = 2'd0,
    PW_SP = 2'd1,
    PW_B  = 2'd2,
    PW_S  = 2'd3
  } pwin_e;

  localparam logic [7:0] SP_RESET = 8'h6F;
endpackage

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate #(
  parameter int SEG_COUNT = 2,
  parameter int IDX_W     = 9
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [7:0]       la_i,
  input  logic [7:0]       seg_i,
  output logic [15:0]      phys_o,
  output logic             oob_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             win_hit_o,
  output logic [1:0]       win_sel_o
);
  localparam int         FLAT_BASE = SEG_COUNT * 128;
  localparam logic [8:0] SEG_LIM   = 9'(SEG_COUNT);

  always_comb begin
    if (la_i[7]) begin
      phys_o = {8'h00, la_i};
      oob_o  = 1'b0;
      idx_o  = IDX_W'(FLAT_BASE) + IDX_W'(la_i[6:0]);
    end else begin
      phys_o = {seg_i, 1'b0, la_i[6:0]};
      oob_o  = ({1'b0, seg_i} >= SEG_LIM);
      idx_o  = IDX_W'({seg_i, la_i[6:0]});
    end
    win_hit_o = (la_i[7:2] == 6'h3F);
    win_sel_o = la_i[1:0];
  end

  assert_flat_bank_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    la_i[7] |-> (phys_o[15:8] == 8'h00 && !oob_o));

  assert_valid_range_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !oob_o |-> ({1'b0, phys_o[15:8]} < SEG_LIM));
endmodule

// File: rtl/seg_ptr_regs.sv
module seg_ptr_regs
  import seg_addr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            wr_win_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [7:0]      wr_data_i,
  input  logic            mod_en_i,
  input  logic [1:0]      mod_sel_i,
  input  logic [1:0]      step_i,
  output logic [3:0][7:0] ptr_o
);
  logic [3:0][7:0] ptr_q, ptr_d;
  logic            upd_en;
  step_e           step;

  assign step   = step_e'(step_i);
  assign upd_en = wr_win_i | mod_en_i;

  always_comb begin
    ptr_d = ptr_q;
    if (mod_en_i) begin
      if (step == STEP_INC) ptr_d[mod_sel_i] = ptr_q[mod_sel_i] + 8'd1;
      else if (step == STEP_DEC) ptr_d[mod_sel_i] = ptr_q[mod_sel_i] - 8'd1;
    end
    // a write to the mapped slot overrides the step
    if (wr_win_i) ptr_d[wr_sel_i] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ptr_q <= {8'h00, 8'h00, SP_RESET, 8'h00};
    end else if (upd_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  assert_b_inc_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (mod_en_i && step == STEP_INC && mod_sel_i == PW_B && !(wr_win_i && wr_sel_i == PW_B))
    |=> ptr_q[PW_B] == $past(ptr_q[PW_B]) + 8'd1);

  assert_x_dec_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (mod_en_i && step == STEP_DEC && mod_sel_i == PW_X && !(wr_win_i && wr_sel_i == PW_X))
    |=> ptr_q[PW_X] == $past(ptr_q[PW_X]) - 8'd1);

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_win_i |=> ptr_q[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: rtl/seg_ram_store.sv
module seg_ram_store #(
  parameter int DEPTH = 384,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = (int'(idx_i) < DEPTH) ? mem_q[idx_i] : 8'h00;

  assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    we_i |-> (int'(idx_i) < DEPTH));
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int SEG_COUNT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        mode_i,
  input  logic        ptr_sel_i,
  input  logic [1:0]  step_i,
  input  logic [7:0]  dir_addr_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_data_i,
  output logic [15:0] phys_addr_o,
  output logic [7:0]  rd_data_o,
  output logic        oor_o
);
  localparam int DEPTH = (SEG_COUNT + 1) * 128;
  localparam int IDX_W = $clog2(DEPTH);

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic [3:0][7:0]  ptr;
  logic [7:0]       la;
  logic [1:0]       mod_sel;
  logic [15:0]      phys;
  logic             oob, win_hit;
  logic [1:0]       win_sel;
  logic [IDX_W-1:0] idx;
  logic [7:0]       ram_rd;
  logic             wr_win, ram_we, mod_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign mod_sel = ptr_sel_i ? PW_X : PW_B;
  assign la      = mode_i ? ptr[mod_sel] : dir_addr_i;

  seg_addr_xlate #(.SEG_COUNT(SEG_COUNT), .IDX_W(IDX_W)) xlate_i (
    .clk(clk), .rst_sn(rst_sn), .la_i(la), .seg_i(ptr[PW_S]),
    .phys_o(phys), .oob_o(oob), .idx_o(idx),
    .win_hit_o(win_hit), .win_sel_o(win_sel)
  );

  assign wr_win = req_i & wr_en_i & win_hit;
  assign ram_we = req_i & wr_en_i & ~win_hit & ~oob;
  assign mod_en = req_i & mode_i & ((step_i == STEP_INC) | (step_i == STEP_DEC));

  seg_ptr_regs ptr_i (
    .clk(clk), .rst_sn(rst_sn),
    .wr_win_i(wr_win), .wr_sel_i(win_sel), .wr_data_i(wr_data_i),
    .mod_en_i(mod_en), .mod_sel_i(mod_sel), .step_i(step_i),
    .ptr_o(ptr)
  );

  seg_ram_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ram_i (
    .clk(clk), .rst_sn(rst_sn), .we_i(ram_we), .idx_i(idx),
    .wdata_i(wr_data_i), .rdata_o(ram_rd)
  );

  always_comb begin
    if (!req_i)       rd_data_o = 8'h00;
    else if (win_hit) rd_data_o = ptr[win_sel];
    else if (oob)     rd_data_o = 8'h00;
    else              rd_data_o = ram_rd;
  end

  assign phys_addr_o = phys;
  assign oor_o       = req_i & oob;

  assert_oor_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    oor_o |-> rd_data_o == 8'h00);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_i |-> (rd_data_o == 8'h00 && !oor_o));

  assert_oor_flat_excl_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    oor_o |-> !la[7]);
endmodule

// File: tb/seg_addr_unit_tb_top.sv
module seg_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, mode_i, ptr_sel_i, wr_en_i;
  logic [1:0]  step_i;
  logic [7:0]  dir_addr_i, wr_data_i;
  logic [15:0] phys_addr_o;
  logic [7:0]  rd_data_o;
  logic        oor_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  seg_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .step_i(step_i), .dir_addr_i(dir_addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .phys_addr_o(phys_addr_o), .rd_data_o(rd_data_o), .oor_o(oor_o)
  );

  // [50:47] req tag, [46] mode, [45] ptr, [44:43] step, [42:35] addr,
  // [34] we, [33:26] wdata, [25:10] phys, [9:2] rd, [1] oor, [0] check rd
  localparam int N = 32;
  localparam logic [50:0] VEC [N] = '{
    {4'd8, 1'b0,1'b0,2'b00,8'hFF,1'b0,8'h00,16'h00FF,8'h00,1'b0,1'b1}, // R8 S
    {4'd8, 1'b0,1'b0,2'b00,8'hFD,1'b0,8'h00,16'h00FD,8'h6F,1'b0,1'b1}, // R8 SP
    {4'd2, 1'b0,1'b0,2'b00,8'h10,1'b1,8'hA5,16'h0010,8'h00,1'b0,1'b0}, // R2
    {4'd9, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0010,8'hA5,1'b0,1'b1}, // R9
    {4'd1, 1'b0,1'b0,2'b00,8'h90,1'b1,8'h3C,16'h0090,8'h00,1'b0,1'b0}, // R1
    {4'd3, 1'b0,1'b0,2'b00,8'hFF,1'b1,8'h01,16'h00FF,8'h00,1'b0,1'b0}, // R3 S=1
    {4'd2, 1'b0,1'b0,2'b00,8'h10,1'b1,8'h5A,16'h0110,8'h00,1'b0,1'b0}, // R2
    {4'd9, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0110,8'h5A,1'b0,1'b1}, // R9
    {4'd1, 1'b0,1'b0,2'b00,8'h90,1'b0,8'h00,16'h0090,8'h3C,1'b0,1'b1}, // R1
    {4'd3, 1'b0,1'b0,2'b00,8'hFF,1'b1,8'h00,16'h00FF,8'h01,1'b0,1'b1}, // R3 S=0
    {4'd9, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0010,8'hA5,1'b0,1'b1}, // R9
    {4'd3, 1'b0,1'b0,2'b00,8'hFE,1'b1,8'h10,16'h00FE,8'h00,1'b0,1'b0}, // R3 B=10
    {4'd4, 1'b1,1'b0,2'b01,8'h00,1'b0,8'h00,16'h0010,8'hA5,1'b0,1'b1}, // R4
    {4'd5, 1'b0,1'b0,2'b00,8'hFE,1'b0,8'h00,16'h00FE,8'h11,1'b0,1'b1}, // R5
    {4'd3, 1'b0,1'b0,2'b00,8'hFC,1'b1,8'h00,16'h00FC,8'h00,1'b0,1'b0}, // R3 X=0
    {4'd4, 1'b1,1'b1,2'b10,8'h00,1'b1,8'h77,16'h0000,8'h00,1'b0,1'b0}, // R4
    {4'd5, 1'b0,1'b0,2'b00,8'hFC,1'b0,8'h00,16'h00FC,8'hFF,1'b0,1'b1}, // R5
    {4'd9, 1'b0,1'b0,2'b00,8'h00,1'b0,8'h00,16'h0000,8'h77,1'b0,1'b1}, // R9
    {4'd3, 1'b0,1'b0,2'b00,8'hFF,1'b1,8'h02,16'h00FF,8'h00,1'b0,1'b0}, // R3 S=2
    {4'd6, 1'b0,1'b0,2'b00,8'h10,1'b1,8'hEE,16'h0210,8'h00,1'b1,1'b1}, // R6
    {4'd6, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0210,8'h00,1'b1,1'b1}, // R6
    {4'd3, 1'b0,1'b0,2'b00,8'hFF,1'b1,8'h01,16'h00FF,8'h02,1'b0,1'b1}, // R3
    {4'd6, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0110,8'h5A,1'b0,1'b1}, // R6
    {4'd3, 1'b0,1'b0,2'b00,8'hFF,1'b1,8'h00,16'h00FF,8'h01,1'b0,1'b1}, // R3
    {4'd6, 1'b0,1'b0,2'b00,8'h10,1'b0,8'h00,16'h0010,8'hA5,1'b0,1'b1}, // R6
    {4'd3, 1'b0,1'b0,2'b00,8'hFE,1'b1,8'hFE,16'h00FE,8'h00,1'b0,1'b0}, // R3 B=FE
    {4'd7, 1'b1,1'b0,2'b01,8'h00,1'b1,8'h40,16'h00FE,8'hFE,1'b0,1'b1}, // R7
    {4'd7, 1'b0,1'b0,2'b00,8'hFE,1'b0,8'h00,16'h00FE,8'h40,1'b0,1'b1}, // R7
    {4'd5, 1'b1,1'b0,2'b11,8'h00,1'b0,8'h00,16'h0040,8'h00,1'b0,1'b0}, // R5
    {4'd5, 1'b0,1'b0,2'b00,8'hFE,1'b0,8'h00,16'h00FE,8'h40,1'b0,1'b1}, // R5
    {4'd5, 1'b1,1'b1,2'b01,8'h00,1'b0,8'h00,16'h00FF,8'h00,1'b0,1'b1}, // R5
    {4'd5, 1'b0,1'b0,2'b00,8'hFC,1'b0,8'h00,16'h00FC,8'h00,1'b0,1'b1}  // R5
  };

  task automatic check8(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic md, input logic ps, input logic [1:0] st,
                       input logic [7:0] ad, input logic we, input logic [7:0] wd);
    @(negedge clk);
    req_i = rq; mode_i = md; ptr_sel_i = ps; step_i = st;
    dir_addr_i = ad; wr_en_i = we; wr_data_i = wd;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_i = 1'b0; mode_i = 1'b0; ptr_sel_i = 1'b0; step_i = 2'b00;
    dir_addr_i = 8'h00; wr_en_i = 1'b0; wr_data_i = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < N; i++) begin
      logic [50:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[50:47], i);
      drive(1'b1, v[46], v[45], v[44:43], v[42:35], v[34], v[33:26]);
      check8({tag, " phys"}, phys_addr_o, v[25:10]);
      check8({tag, " oor"}, {15'd0, oor_o}, {15'd0, v[1]});
      if (v[0]) check8({tag, " rd"}, {8'd0, rd_data_o}, {8'd0, v[9:2]});
    end

    // R10: idle cycle carrying write and step controls on pointer B
    drive(1'b0, 1'b1, 1'b0, 2'b01, 8'hFE, 1'b1, 8'h99);
    check8("R10 idle rd", {8'd0, rd_data_o}, 16'h0000);
    check8("R10 idle oor", {15'd0, oor_o}, 16'h0000);
    drive(1'b0, 1'b0, 1'b0, 2'b00, 8'hFE, 1'b1, 8'h99);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFE, 1'b0, 8'h00);
    check8("R10 B unchanged", {8'd0, rd_data_o}, 16'h0040);

    // R8: reset again after pointers were changed
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFF, 1'b1, 8'h01);
    do_reset();
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFE, 1'b0, 8'h00);
    check8("R8 B reset", {8'd0, rd_data_o}, 16'h0000);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFF, 1'b0, 8'h00);
    check8("R8 S reset", {8'd0, rd_data_o}, 16'h0000);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFD, 1'b0, 8'h00);
    check8("R8 SP reset", {8'd0, rd_data_o}, 16'h006F);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'hFC, 1'b0, 8'h00);
    check8("R8 X reset", {8'd0, rd_data_o}, 16'h0000);
    // R2: segment 0 content survives reset of the pointers
    drive(1'b1, 1'b0, 1'b0, 2'b00, 8'h10, 1'b0, 8'h00);
    check8("R2 seg0 after reset", {8'd0, rd_data_o}, 16'h00A5);

    drive(1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule